// File: doc/BRIEF.md
# Sync Detect Masking and Clamp Source Selection

This block sits after the analog sync slicers of a video front end. It takes up to three raw composite-sync levels, synchronizes each to the core clock, and follows the one picked by a source-select field. Each rising edge of the selected level that the block accepts gives a single-cycle sync-detect pulse. The same edge opens a blanking window of a fixed number of clock cycles. During that window further edges are thrown away, so that noise away from the true sync period cannot start a false clamp. A one-cycle clear strobe ends the window early.

The second half of the block routes clamp timing. The sync-tip and pedestal clamp outputs normally carry the internally generated pulses. When external clamping is enabled with a non-zero clamp mode, a shared pad is treated as an input. Its synchronized level replaces one or both internal pulses. When the pad is not needed as an input, the block drives it with an internal timing signal picked by a monitor-select field, so the signal can be observed. All control fields come in as plain input ports, as they would from a register file. The nominal clock is about 27 MHz, which gives a blanking window of roughly 57 us.

Top module: `sync_mask_clamp`

## Requirements
- R1: A rising edge on the selected sync input that is first sampled at clock edge k, with the window closed, drives `sync_det` high for exactly one cycle, starting just after clock edge k+2 (two synchronizer flops, then one registered output).
- R2: With `src_sel` = 00, `sync_det` and `mask_active` are low from the next cycle onward, whatever happens on the sync inputs.
- R3: An accepted edge raises `mask_active` in the same cycle as its `sync_det` pulse, and holds it high for exactly MASK_LEN (default 1536) consecutive cycles.
- R4: No edge produces a `sync_det` pulse while `mask_active` is high, and that includes an edge that is evaluated in the window's final cycle.
- R5: A `mask_clr` strobe that is sampled while the window is open lowers `mask_active` on the next cycle. An edge evaluated in that same cycle is ignored, and later edges are accepted. While the window is closed, an accepted edge takes priority over a simultaneous clear.
- R6: Source codes select inputs as follows: 01 selects `sync_raw[0]`, 10 selects `sync_raw[1]`, 11 selects `sync_raw[2]`. Edges on inputs that are not selected have no effect on `sync_det`.
- R7: External mode is active when `ext_clamp_en`=1 and `clamp_mode`≠00. In this mode `clamp_pin_oe` is 0, and the pad level replaces the tip clamp (mode 01), the pedestal clamp (mode 10) or both (mode 11). The pad level sampled at edge k appears just after edge k+1.
- R8: A clamp output that is not taken over by the external pad equals its internal input in the same cycle.
- R9: When external mode is off, `clamp_pin_oe` is 1 and `clamp_pin_out` carries the signal picked by `mon_sel`: 00 selects the tip clamp input, 01 the pedestal clamp input, 10 `sync_det`, and 11 drives low.
- R10: In external mode `clamp_pin_out` is held low.
- R11: During reset `sync_det` and `mask_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_raw | input | NUM_SRC | Raw sync levels from the slicers |
| src_sel | input | SEL_W | Sync source select, 0 = none |
| mask_clr | input | 1 | One-cycle strobe that ends the blanking window |
| ext_clamp_en | input | 1 | Enables external clamp timing |
| clamp_mode | input | 2 | Clamp outputs taken from the pad |
| mon_sel | input | 2 | Monitor signal select |
| tip_clamp_in | input | 1 | Internal sync-tip clamp pulse |
| ped_clamp_in | input | 1 | Internal pedestal clamp pulse |
| clamp_pin_in | input | 1 | Pad input level |
| sync_det | output | 1 | Accepted sync-detect pulse |
| mask_active | output | 1 | Blanking window open |
| tip_clamp_out | output | 1 | Selected sync-tip clamp timing |
| ped_clamp_out | output | 1 | Selected pedestal clamp timing |
| clamp_pin_out | output | 1 | Pad output value |
| clamp_pin_oe | output | 1 | Pad output enable |

## Verification
The collision that matters is a clear strobe and a rising edge falling on the same clock edge. The bench lines up a raw rise two cycles ahead of a `mask_clr` so that both are evaluated together while the window is open. It then expects no pulse and a closed window, and expects the next rise to be accepted. A second collision places a rise exactly on the window's last cycle, where the window closing and the edge coincide: the pulse must stay suppressed. Random traffic repeats both cases at random alignments against a cycle-level reference model.

// File: rtl/smc_pkg.sv
// Shared encodings for the sync mask / clamp routing block.
package smc_pkg;

    // Signal driven onto the shared pad in monitor mode.
    typedef enum logic [1:0] {
        MON_TIP = 2'b00,
        MON_PED = 2'b01,
        MON_DET = 2'b10,
        MON_OFF = 2'b11
    } mon_sel_e;

    // Which clamp outputs take the pad level in external mode.
    typedef enum logic [1:0] {
        CLM_INT      = 2'b00,
        CLM_EXT_TIP  = 2'b01,
        CLM_EXT_PED  = 2'b10,
        CLM_EXT_BOTH = 2'b11
    } clamp_mode_e;

endpackage

// File: rtl/smc_sync_chain.sv
// Multi-bit flop synchronizer. Each bit is treated independently; the caller
// must tolerate one cycle of uncertainty on asynchronous changes.
module smc_sync_chain #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/smc_sync_front.sv
// Synchronizes every raw sync input, selects one by source code and flags
// its rising edges. Code 0 selects nothing; code i+1 selects input i.
module smc_sync_front #(
    parameter int NUM_SRC = 3,
    parameter int STAGES  = 2,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_raw,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               src_off,
    output logic               sel_rise
);
    logic [NUM_SRC-1:0] synced;
    logic               sel_level;
    logic               prev_level;

    smc_sync_chain #(.WIDTH(NUM_SRC), .STAGES(STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_raw),
        .q     (synced)
    );

    // Pick the synchronized level matching the source code.
    always_comb begin
        sel_level = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_sel == SEL_W'(i + 1)) sel_level = synced[i];
        end
    end

    // Remember the previous selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_level <= 1'b0;
        else        prev_level <= sel_level;
    end

    assign src_off  = (src_sel == '0);
    assign sel_rise = sel_level & ~prev_level & ~src_off;
endmodule

// File: rtl/smc_mask_window.sv
// Accepts sync edges while no window is open, emits a one-cycle detect pulse
// and opens a fixed-length blanking window. Assumes the edge input is already
// synchronous. Accept outranks clear; clear outranks the window timeout.
module smc_mask_window #(
    parameter int MASK_LEN = 1536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic clr,
    input  logic src_off,
    output logic det,
    output logic active
);
    localparam int CNT_W = (MASK_LEN > 1) ? $clog2(MASK_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MASK_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept = rise & ~active & ~src_off;

    // Register the detect pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) det <= 1'b0;
        else        det <= accept;
    end

    // Window state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (src_off) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (accept) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (clr) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smc_clamp_route.sv
// Chooses internal or pad-sourced clamp timing and drives the shared pad
// with a monitor signal when it is not an input. Pad input is asynchronous
// and synchronized here; internal pulses are assumed synchronous.
module smc_clamp_route
    import smc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_en,
    input  logic [1:0] clamp_mode,
    input  logic [1:0] mon_sel,
    input  logic       tip_in,
    input  logic       ped_in,
    input  logic       det,
    input  logic       pin_in,
    output logic       tip_out,
    output logic       ped_out,
    output logic       pin_out,
    output logic       pin_oe
);
    clamp_mode_e mode;
    mon_sel_e    msel;
    logic        pin_sync;
    logic        ext_use;
    logic        mon_val;

    assign mode = clamp_mode_e'(clamp_mode);
    assign msel = mon_sel_e'(mon_sel);

    smc_sync_chain #(.WIDTH(1), .STAGES(STAGES)) i_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign ext_use = ext_en & (mode != CLM_INT);

    // Replace internal clamp pulses by the pad level as the mode asks.
    always_comb begin
        tip_out = tip_in;
        ped_out = ped_in;
        if (ext_use) begin
            if (mode == CLM_EXT_TIP || mode == CLM_EXT_BOTH) tip_out = pin_sync;
            if (mode == CLM_EXT_PED || mode == CLM_EXT_BOTH) ped_out = pin_sync;
        end
    end

    // Select the monitor signal.
    always_comb begin
        case (msel)
            MON_TIP: mon_val = tip_in;
            MON_PED: mon_val = ped_in;
            MON_DET: mon_val = det;
            default: mon_val = 1'b0;
        endcase
    end

    assign pin_oe  = ~ext_use;
    assign pin_out = ext_use ? 1'b0 : mon_val;
endmodule

// File: rtl/sync_mask_clamp.sv
// Top level: sync source selection with post-edge blanking, plus clamp timing
// source selection and pad monitor. Control fields are static register bits
// except mask_clr, a one-cycle strobe.
module sync_mask_clamp #(
    parameter int NUM_SRC  = 3,
    parameter int MASK_LEN = 1536,
    parameter int STAGES   = 2,
    localparam int SEL_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_raw,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               mask_clr,
    input  logic               ext_clamp_en,
    input  logic [1:0]         clamp_mode,
    input  logic [1:0]         mon_sel,
    input  logic               tip_clamp_in,
    input  logic               ped_clamp_in,
    input  logic               clamp_pin_in,
    output logic               sync_det,
    output logic               mask_active,
    output logic               tip_clamp_out,
    output logic               ped_clamp_out,
    output logic               clamp_pin_out,
    output logic               clamp_pin_oe
);
    logic src_off;
    logic sel_rise;

    smc_sync_front #(.NUM_SRC(NUM_SRC), .STAGES(STAGES), .SEL_W(SEL_W)) i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_raw (sync_raw),
        .src_sel  (src_sel),
        .src_off  (src_off),
        .sel_rise (sel_rise)
    );

    smc_mask_window #(.MASK_LEN(MASK_LEN)) i_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (sel_rise),
        .clr     (mask_clr),
        .src_off (src_off),
        .det     (sync_det),
        .active  (mask_active)
    );

    smc_clamp_route #(.STAGES(STAGES)) i_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_en     (ext_clamp_en),
        .clamp_mode (clamp_mode),
        .mon_sel    (mon_sel),
        .tip_in     (tip_clamp_in),
        .ped_in     (ped_clamp_in),
        .det        (sync_det),
        .pin_in     (clamp_pin_in),
        .tip_out    (tip_clamp_out),
        .ped_out    (ped_clamp_out),
        .pin_out    (clamp_pin_out),
        .pin_oe     (clamp_pin_oe)
    );
endmodule

// File: rtl/smc_checker.sv
// Temporal checks on the sync mask / clamp block, bound to its top level.
module smc_checker #(
    parameter int SEL_W    = 2,
    parameter int MASK_LEN = 1536
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] src_sel,
    input logic             mask_clr,
    input logic             ext_clamp_en,
    input logic [1:0]       clamp_mode,
    input logic [1:0]       mon_sel,
    input logic             sync_det,
    input logic             mask_active,
    input logic             clamp_pin_out,
    input logic             clamp_pin_oe
);
    localparam int RUN_W = $clog2(MASK_LEN + 2);

    logic [RUN_W-1:0] run;
    logic             seen;

    // Count consecutive open-window cycles and note the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= '0;
            seen <= 1'b0;
        end else begin
            seen <= 1'b1;
            run  <= mask_active ? run + 1'b1 : '0;
        end
    end

    p_det_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_det |=> !sync_det);

    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == '0) |=> (!sync_det && !mask_active));

    p_det_opens_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_det |-> mask_active);

    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_active |-> (run < RUN_W'(MASK_LEN)));

    p_no_det_in_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && seen) |-> !$past(mask_active));

    p_clear_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && mask_active) |=> !mask_active);

    p_pad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clamp_en && clamp_mode != 2'b00) |-> (!clamp_pin_oe && !clamp_pin_out));

    p_mon_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clamp_en && mon_sel == 2'b11) |-> (clamp_pin_oe && !clamp_pin_out));
endmodule

bind sync_mask_clamp smc_checker #(.SEL_W(SEL_W), .MASK_LEN(MASK_LEN)) i_smc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_sel       (src_sel),
    .mask_clr      (mask_clr),
    .ext_clamp_en  (ext_clamp_en),
    .clamp_mode    (clamp_mode),
    .mon_sel       (mon_sel),
    .sync_det      (sync_det),
    .mask_active   (mask_active),
    .clamp_pin_out (clamp_pin_out),
    .clamp_pin_oe  (clamp_pin_oe)
);

// File: tb/test_sync_mask_clamp.sv
`timescale 1ns/1ps
module test_sync_mask_clamp;
    localparam int NUM_SRC  = 3;
    localparam int MASK_LEN = 1536;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sync_raw = '0;
    logic [1:0] src_sel = '0;
    logic       mask_clr = 1'b0;
    logic       ext_clamp_en = 1'b0;
    logic [1:0] clamp_mode = '0;
    logic [1:0] mon_sel = '0;
    logic       tip_clamp_in = 1'b0;
    logic       ped_clamp_in = 1'b0;
    logic       clamp_pin_in = 1'b0;
    logic       sync_det, mask_active, tip_clamp_out, ped_clamp_out, clamp_pin_out, clamp_pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sync_mask_clamp #(.NUM_SRC(NUM_SRC), .MASK_LEN(MASK_LEN)) i_sync_mask_clamp (
        .clk(clk), .rst_n(rst_n), .sync_raw(sync_raw), .src_sel(src_sel),
        .mask_clr(mask_clr), .ext_clamp_en(ext_clamp_en), .clamp_mode(clamp_mode),
        .mon_sel(mon_sel), .tip_clamp_in(tip_clamp_in), .ped_clamp_in(ped_clamp_in),
        .clamp_pin_in(clamp_pin_in), .sync_det(sync_det), .mask_active(mask_active),
        .tip_clamp_out(tip_clamp_out), .ped_clamp_out(ped_clamp_out),
        .clamp_pin_out(clamp_pin_out), .clamp_pin_oe(clamp_pin_oe)
    );

    // Reference model state, derived from the requirements.
    logic [2:0] m_s1, m_s2;
    logic       m_prev, m_det, m_act, m_p1, m_p2;
    int         m_cnt;

    function automatic logic sel_of(input logic [2:0] v, input logic [1:0] s);
        return (s == 2'b00) ? 1'b0 : v[s - 1];
    endfunction

    // Expected {tip, ped, oe, pad out} from R7..R10.
    function automatic logic [3:0] exp_route(input logic en, input logic [1:0] md,
            input logic [1:0] ms, input logic tip, input logic ped,
            input logic det, input logic pad);
        logic ext, t, p, o;
        ext = en && (md != 2'b00);
        t = (ext && md[0]) ? pad : tip;
        p = (ext && md[1]) ? pad : ped;
        case (ms)
            2'b00: o = tip;
            2'b01: o = ped;
            2'b10: o = det;
            default: o = 1'b0;
        endcase
        return {t, p, !ext, ext ? 1'b0 : o};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= 1'b0; m_det <= 1'b0;
            m_act <= 1'b0; m_cnt <= 0; m_p1 <= 1'b0; m_p2 <= 1'b0;
        end else begin
            logic lvl, acc;
            lvl = sel_of(m_s2, src_sel);
            acc = (src_sel != 0) && lvl && !m_prev && !m_act;
            m_s1 <= sync_raw; m_s2 <= m_s1; m_prev <= lvl;
            m_p1 <= clamp_pin_in; m_p2 <= m_p1;
            m_det <= acc;
            if (src_sel == 0)      begin m_act <= 1'b0; m_cnt <= 0; end
            else if (acc)          begin m_act <= 1'b1; m_cnt <= 0; end
            else if (mask_clr)     begin m_act <= 1'b0; m_cnt <= 0; end
            else if (m_act) begin
                if (m_cnt == MASK_LEN - 1) begin m_act <= 1'b0; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] e;
            e = exp_route(ext_clamp_en, clamp_mode, mon_sel, tip_clamp_in, ped_clamp_in, m_det, m_p2);
            check("R1/R4/R6", "sync_det", sync_det, m_det);
            check("R3/R5", "mask_active", mask_active, m_act);
            check("R7/R8", "tip_clamp_out", tip_clamp_out, e[3]);
            check("R7/R8", "ped_clamp_out", ped_clamp_out, e[2]);
            check("R7/R9", "clamp_pin_oe", clamp_pin_oe, e[1]);
            check("R9/R10", "clamp_pin_out", clamp_pin_out, e[0]);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Count sync_det pulses over n cycles (sampled mid-cycle).
    task automatic count_det(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sync_det) c++;
            @(posedge clk);
            #1;
        end
    endtask

    // Raise input 0 and wait until the pulse is seen; leaves input low.
    task automatic fire_and_wait();
        sync_raw[0] = 1'b1;
        step(1);
        sync_raw[0] = 1'b0;
        while (!sync_det) step(1);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c, len;
        void'($urandom(32'd20250));
        step(3);
        check("R11", "sync_det in reset", sync_det, 0);
        check("R11", "mask_active in reset", mask_active, 0);
        rst_n = 1'b1;
        step(4);

        // R1 / R3: single pulse and window length.
        src_sel = 2'b01;
        step(3);
        sync_raw[0] = 1'b1;
        step(1);
        step(1);
        @(negedge clk);
        check("R1", "no pulse before k+2", sync_det, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check("R1", "pulse after k+2", sync_det, 1);
        check("R3", "window opens with pulse", mask_active, 1);
        len = 0;
        while (mask_active && len < MASK_LEN + 10) begin
            len++;
            @(posedge clk); #1;
            @(negedge clk);
        end
        check("R3", "window length", len, MASK_LEN);
        sync_raw[0] = 1'b0;
        step(3);

        // R4: edge evaluated on the last window cycle is ignored.
        fire_and_wait();
        @(posedge clk); #1;
        step(MASK_LEN - 4);
        sync_raw[0] = 1'b1;
        count_det(8, c);
        check("R4", "edge on terminal cycle", c, 0);
        check("R4", "window closed after terminal", mask_active, 0);
        sync_raw[0] = 1'b0;
        step(3);
        sync_raw[0] = 1'b1;
        count_det(5, c);
        check("R4", "next edge accepted", c, 1);
        sync_raw[0] = 1'b0;

        // R5: clear and edge evaluated on the same edge.
        step(120);
        check("R5", "window open before clear", mask_active, 1);
        sync_raw[0] = 1'b1;
        step(2);
        mask_clr = 1'b1;
        step(1);
        mask_clr = 1'b0;
        count_det(3, c);
        check("R5", "edge with clear ignored", c, 0);
        check("R5", "window closed by clear", mask_active, 0);
        sync_raw[0] = 1'b0;
        step(3);
        sync_raw[0] = 1'b1;
        count_det(5, c);
        check("R5", "edge after clear accepted", c, 1);
        sync_raw[0] = 1'b0;
        mask_clr = 1'b1; step(1); mask_clr = 1'b0;
        step(3);

        // R6: unselected inputs ignored.
        src_sel = 2'b10;
        step(4);
        sync_raw = 3'b101;
        count_det(6, c);
        check("R6", "unselected inputs", c, 0);
        sync_raw = 3'b000;
        step(3);
        sync_raw[1] = 1'b1;
        count_det(5, c);
        check("R6", "selected input 2", c, 1);
        sync_raw = 3'b000;

        // R2: no source.
        src_sel = 2'b00;
        step(2);
        sync_raw = 3'b111;
        count_det(6, c);
        check("R2", "no source pulses", c, 0);
        check("R2", "no source window", mask_active, 0);
        sync_raw = 3'b000;
        step(3);

        // R7 / R8 / R9 / R10: random traffic against the model.
        src_sel = 2'b11;
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(39) == 0) sync_raw[$urandom_range(2)] ^= 1'b1;
            mask_clr = ($urandom_range(299) == 0);
            if ($urandom_range(1999) == 0) src_sel = 2'($urandom_range(3));
            if ($urandom_range(49) == 0) begin
                ext_clamp_en = 1'($urandom_range(1));
                clamp_mode   = 2'($urandom_range(3));
                mon_sel      = 2'($urandom_range(3));
            end
            tip_clamp_in = 1'($urandom_range(1));
            ped_clamp_in = 1'($urandom_range(1));
            clamp_pin_in = 1'($urandom_range(1));
            step(1);
        end
        mask_clr = 1'b0;
        step(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule